// File: doc/BRIEF.md
# Robbed-Bit Signaling Extractor with Freeze

This block sits behind a T1 framer and watches the frame-aligned receive bit stream. Each bit arrives with its frame number inside the multiframe, its time-slot number and its bit position inside the slot. In every sixth frame the block takes the last bit of each of the 24 time slots as a signaling bit. It collects these bits in a shadow store. At the last bit of the multiframe it copies the whole shadow store, in one step, into a register bank that holds four signaling bits per channel.

Two multiframe formats are supported. The 24-frame extended superframe carries four signaling bits per channel. The 12-frame superframe carries two, and the block repeats them into the lower half of the nibble. A freeze state protects the bank from corrupt data. Loss of signal, loss of frame alignment or a receive slip starts the freeze, and a configuration input can turn this automatic start off. A signaling resynchronization event always starts the freeze and also raises a one-cycle interrupt.

The freeze ends only after one complete multiframe has been received while no fault was present. The bank is visible as a flat vector and through a byte read port. The same read port also returns the freeze status.

Top module: `rbs_sig_extract`

## Requirements
- R1: After a synchronous reset, the bank is all zero and `freeze_o` and `resync_irq` are low.
- R2: A bit is captured only when all of the following hold: `din_vld` is high, `bit_idx` is 7 (bit 0 is the first bit of the slot), `slot_idx` is below 24, and the 0-based `frm_idx` is 5, 11, 17 or 23 and inside the active multiframe length. Every other bit has no effect on the bank.
- R3: With `esf_mode`=1, a channel nibble holds, from bit 3 down to bit 0, the bits captured in frames 5, 11, 17 and 23.
- R4: With `esf_mode`=0, the multiframe is 12 frames long. The frame-5 bit goes to nibble bits 3 and 1, and the frame-11 bit goes to nibble bits 2 and 0.
- R5: Channel (slot) s is stored in byte s/2 of the bank, in the upper nibble for even s and in the lower nibble for odd s. Byte k occupies `sig_bank[8k+7:8k]`.
- R6: The bank changes only at the clock edge that samples the last bit of a multiframe (last frame, slot 23, bit 7, valid). At that edge every channel is updated together, and the update includes that last bit.
- R7: With `auto_frz_off`=0, a high level on `los`, `lof` or `slip` sets `freeze_o` at the next edge. While frozen, multiframe ends do not update the bank.
- R8: With `auto_frz_off`=1, `los`, `lof` and `slip` never set the freeze.
- R9: A `cas_resync` pulse sets `freeze_o` whatever the value of `auto_frz_off`, and produces `resync_irq` high for exactly the following cycle.
- R10: A freeze ends at the last bit of the first multiframe that begins, and ends, with no fault or resync present at its first bit or during it. At that same edge the multiframe's data is committed.
- R11: `rd_data` returns bank byte `rd_addr` for addresses 0 to 11. Address 12 returns the freeze status in bit 0 with the other bits zero. Higher addresses return zero.
- R12: Cycles with `din_vld`=0 do not affect the bank, the freeze state or the multiframe boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Receive data bit |
| din_vld | input | 1 | Data bit and position are valid |
| esf_mode | input | 1 | 1 = 24-frame format, 0 = 12-frame format |
| frm_idx | input | 5 | Frame number inside the multiframe, 0-based |
| slot_idx | input | 5 | Time-slot number, 0-based |
| bit_idx | input | 3 | Bit number inside the slot, 0 = first |
| los | input | 1 | Loss of signal |
| lof | input | 1 | Loss of frame alignment |
| slip | input | 1 | Receive slip |
| auto_frz_off | input | 1 | Disable the fault-driven freeze |
| cas_resync | input | 1 | Signaling multiframe resynchronized |
| freeze_o | output | 1 | Freeze active |
| resync_irq | output | 1 | One-cycle pulse after a resync |
| sig_bank | output | 96 | Flat signaling bank, 12 bytes |
| rd_addr | input | 4 | Byte read address |
| rd_data | output | 8 | Byte read data |

## Verification
A behavioural model is compared with the design on every cycle. It is driven with complete 24-frame multiframes whose data comes from a per-multiframe hash. Differing multiframes therefore separate correct lane placement and byte order from swapped nibbles or a wrong frame choice. Additional patterns cover:
- Invalid cycles that carry inverted data at capture positions, to show that `din_vld` gates the capture.
- 12-frame multiframes, to show the bit duplication and the shorter boundary.
- Faults at the start and in the middle of multiframes, and during an armed multiframe, to show when the freeze is held and when it is released.
- Faults and a resync with the automatic freeze disabled, to separate the two freeze sources.

// File: rtl/rbs_pkg.sv
`timescale 1ns/1ps
package rbs_pkg;
    localparam int unsigned FRM_W      = 5;
    localparam int unsigned BIT_W      = 3;
    localparam int unsigned SIG_W      = 4;
    localparam int unsigned ROB_GAP    = 6;
    localparam int unsigned ESF_FRAMES = 24;
    localparam int unsigned SF_FRAMES  = 12;
    localparam logic [BIT_W-1:0] LSB_POS = BIT_W'(7);

    typedef struct packed {
        logic       hit;
        logic [1:0] sel;
    } rob_t;

    typedef struct packed {
        logic       cap;
        logic [1:0] sel;
        logic       sf;
        logic       first;
        logic       last;
    } pos_evt_t;

    typedef enum logic [1:0] {
        FZ_OPEN  = 2'd0,
        FZ_HELD  = 2'd1,
        FZ_ARMED = 2'd2
    } frz_st_e;

    function automatic rob_t rob_lookup(input logic [FRM_W-1:0] frm);
        rob_t r;
        int unsigned f;
        f     = int'(frm) + 1;
        r.hit = (f % ROB_GAP) == 0;
        r.sel = 2'((f / ROB_GAP) - 1);
        return r;
    endfunction

    function automatic logic [SIG_W-1:0] lane_mask(input logic [1:0] sel, input logic sf);
        if (sf) return sel[0] ? 4'b0101 : 4'b1010;
        return 4'b1000 >> sel;
    endfunction
endpackage

// File: rtl/rbs_pos_decode.sv
`timescale 1ns/1ps
module rbs_pos_decode
    import rbs_pkg::*;
#(
    parameter int unsigned NCH  = 24,
    parameter int unsigned CH_W = 5
) (
    input  logic             din_vld,
    input  logic             esf_mode,
    input  logic [FRM_W-1:0] frm_idx,
    input  logic [CH_W-1:0]  slot_idx,
    input  logic [BIT_W-1:0] bit_idx,
    output pos_evt_t         evt
);
    rob_t             rob;
    logic [FRM_W-1:0] last_frm;

    assign rob      = rob_lookup(frm_idx);
    assign last_frm = esf_mode ? FRM_W'(ESF_FRAMES - 1) : FRM_W'(SF_FRAMES - 1);

    always_comb begin
        evt.sf    = !esf_mode;
        evt.sel   = rob.sel;
        evt.cap   = din_vld && rob.hit && (frm_idx <= last_frm)
                    && (slot_idx < CH_W'(NCH)) && (bit_idx == LSB_POS);
        evt.first = din_vld && (frm_idx == '0) && (slot_idx == '0) && (bit_idx == '0);
        evt.last  = din_vld && (frm_idx == last_frm)
                    && (slot_idx == CH_W'(NCH - 1)) && (bit_idx == LSB_POS);
    end
endmodule

// File: rtl/rbs_freeze_ctl.sv
`timescale 1ns/1ps
module rbs_freeze_ctl
    import rbs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fault,
    input  logic resync,
    input  logic mf_first,
    input  logic mf_last,
    output logic frz,
    output logic release_now,
    output logic irq
);
    frz_st_e st_q, st_d;
    logic    irq_q;
    logic    upset;

    assign upset       = fault || resync;
    assign release_now = (st_q == FZ_ARMED) && mf_last && !upset;
    assign frz         = (st_q != FZ_OPEN);
    assign irq         = irq_q;

    always_comb begin
        st_d = st_q;
        if (upset)                              st_d = FZ_HELD;
        else if (release_now)                   st_d = FZ_OPEN;
        else if ((st_q == FZ_HELD) && mf_first) st_d = FZ_ARMED;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= FZ_OPEN;
            irq_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            irq_q <= resync;
        end
    end

    a_r9_irq_follows: assert property (@(posedge clk) disable iff (rst)
        resync |=> irq);
    a_r9_irq_single: assert property (@(posedge clk) disable iff (rst)
        (!resync && !rst) |=> !irq);
    a_r10_release_at_end: assert property (@(posedge clk) disable iff (rst)
        (frz && !upset && !mf_last) |=> frz);
    a_r8_quiet_stays_open: assert property (@(posedge clk) disable iff (rst)
        (!frz && !upset) |=> !frz);
endmodule

// File: rtl/rbs_sig_store.sv
`timescale 1ns/1ps
module rbs_sig_store
    import rbs_pkg::*;
#(
    parameter int unsigned NCH  = 24,
    parameter int unsigned CH_W = 5,
    localparam int unsigned BANK_W = NCH * SIG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  pos_evt_t          evt,
    input  logic [CH_W-1:0]   ch,
    input  logic              din,
    input  logic              commit,
    output logic [BANK_W-1:0] bank
);
    logic [SIG_W-1:0] mask;

    assign mask = lane_mask(evt.sel, evt.sf);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int unsigned OFS = 8 * (c / 2) + ((c % 2 == 0) ? SIG_W : 0);
        logic [SIG_W-1:0] sh_q, sh_d, nib_q;

        always_comb begin
            sh_d = sh_q;
            if (evt.cap && (ch == CH_W'(c)))
                sh_d = (sh_q & ~mask) | ({SIG_W{din}} & mask);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                sh_q  <= '0;
                nib_q <= '0;
            end else begin
                sh_q <= sh_d;
                if (commit) nib_q <= sh_d;
            end
        end

        assign bank[OFS +: SIG_W] = nib_q;
    end

    a_r6_only_on_commit: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(bank));
endmodule

// File: rtl/rbs_sig_extract.sv
`timescale 1ns/1ps
module rbs_sig_extract
    import rbs_pkg::*;
#(
    parameter int unsigned NCH = 24,
    localparam int unsigned CH_W   = $clog2(NCH + 1),
    localparam int unsigned NBYTE  = NCH / 2,
    localparam int unsigned ADDR_W = $clog2(NBYTE + 1),
    localparam int unsigned BANK_W = NCH * SIG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              din,
    input  logic              din_vld,
    input  logic              esf_mode,
    input  logic [FRM_W-1:0]  frm_idx,
    input  logic [CH_W-1:0]   slot_idx,
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic              los,
    input  logic              lof,
    input  logic              slip,
    input  logic              auto_frz_off,
    input  logic              cas_resync,
    output logic              freeze_o,
    output logic              resync_irq,
    output logic [BANK_W-1:0] sig_bank,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    pos_evt_t evt;
    logic     fault;
    logic     release_now;
    logic     commit;

    assign fault  = (los || lof || slip) && !auto_frz_off;
    assign commit = evt.last && (!freeze_o || release_now);

    rbs_pos_decode #(.NCH(NCH), .CH_W(CH_W)) u_dec (
        .din_vld (din_vld),
        .esf_mode(esf_mode),
        .frm_idx (frm_idx),
        .slot_idx(slot_idx),
        .bit_idx (bit_idx),
        .evt     (evt)
    );

    rbs_freeze_ctl u_frz (
        .clk        (clk),
        .rst        (rst),
        .fault      (fault),
        .resync     (cas_resync),
        .mf_first   (evt.first),
        .mf_last    (evt.last),
        .frz        (freeze_o),
        .release_now(release_now),
        .irq        (resync_irq)
    );

    rbs_sig_store #(.NCH(NCH), .CH_W(CH_W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt),
        .ch    (slot_idx),
        .din   (din),
        .commit(commit),
        .bank  (sig_bank)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr < ADDR_W'(NBYTE))       rd_data = sig_bank[int'(rd_addr) * 8 +: 8];
        else if (rd_addr == ADDR_W'(NBYTE)) rd_data = {7'd0, freeze_o};
    end

    a_r7_fault_freezes: assert property (@(posedge clk) disable iff (rst)
        ((los || lof || slip) && !auto_frz_off) |=> freeze_o);
    a_r7_frozen_hold: assert property (@(posedge clk) disable iff (rst)
        (freeze_o && !release_now) |=> $stable(sig_bank));
    a_r12_invalid_ignored: assert property (@(posedge clk) disable iff (rst)
        !din_vld |=> $stable(sig_bank));
endmodule

// File: tb/rbs_sig_extract_bench.sv
`timescale 1ns/1ps
module rbs_sig_extract_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        din = 1'b0, din_vld = 1'b0, esf_mode = 1'b1;
    logic [4:0]  frm_idx = '0, slot_idx = '0;
    logic [2:0]  bit_idx = '0;
    logic        los = 1'b0, lof = 1'b0, slip = 1'b0;
    logic        auto_frz_off = 1'b0, cas_resync = 1'b0;
    logic        freeze_o, resync_irq;
    logic [95:0] sig_bank;
    logic [3:0]  rd_addr = '0;
    logic [7:0]  rd_data;

    int checks = 0;
    int fails  = 0;
    int rd_cnt = 0;

    logic [3:0]  m_sh [24];
    logic [95:0] m_bank = '0;
    int          m_st   = 0;
    logic        m_irq  = 1'b0;

    always #2 clk = ~clk;

    rbs_sig_extract u_rbs_sig_extract (
        .clk(clk), .rst(rst), .din(din), .din_vld(din_vld), .esf_mode(esf_mode),
        .frm_idx(frm_idx), .slot_idx(slot_idx), .bit_idx(bit_idx),
        .los(los), .lof(lof), .slip(slip), .auto_frz_off(auto_frz_off),
        .cas_resync(cas_resync), .freeze_o(freeze_o), .resync_irq(resync_irq),
        .sig_bank(sig_bank), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input bit d, input bit v, input int frm, input int slot, input int bt,
                        input bit l1, input bit l2, input bit sl, input bit rs);
        bit   fault, first, last, commit;
        int   nf;
        logic [7:0] exp_rd;
        din = d; din_vld = v; frm_idx = 5'(frm); slot_idx = 5'(slot); bit_idx = 3'(bt);
        los = l1; lof = l2; slip = sl; cas_resync = rs;
        rd_addr = 4'(rd_cnt % 16);
        rd_cnt++;
        @(posedge clk);
        #1;
        nf    = esf_mode ? 24 : 12;
        fault = (l1 || l2 || sl) && !auto_frz_off;
        first = v && frm == 0 && slot == 0 && bt == 0;
        last  = v && frm == nf - 1 && slot == 23 && bt == 7;
        if (v && bt == 7 && slot < 24 && frm < nf && ((frm + 1) % 6) == 0) begin
            int k = (frm + 1) / 6 - 1;
            m_sh[slot][3 - k] = d;
            if (!esf_mode) m_sh[slot][1 - k] = d;
        end
        commit = last && (m_st == 0 || (m_st == 2 && !fault && !rs));
        if (commit)
            for (int c = 0; c < 24; c++) m_bank[8 * (c / 2) + ((c % 2 == 0) ? 4 : 0) +: 4] = m_sh[c];
        if (fault || rs)                            m_st = 1;
        else if (m_st == 2 && last)                 m_st = 0;
        else if (m_st == 1 && first)                m_st = 2;
        m_irq = rs;
        if (rd_addr < 12)       exp_rd = m_bank[8 * int'(rd_addr) +: 8];
        else if (rd_addr == 12) exp_rd = {7'd0, m_st != 0};
        else                    exp_rd = 8'd0;
        chk(sig_bank === m_bank, "R2 R3 R5 R6 bank", sig_bank, m_bank);
        chk(freeze_o === (m_st != 0), "R7 R8 R10 freeze", 96'(freeze_o), 96'(m_st != 0));
        chk(resync_irq === m_irq, "R9 irq", 96'(resync_irq), 96'(m_irq));
        chk(rd_data === exp_rd, "R11 read", 96'(rd_data), 96'(exp_rd));
    endtask

    function automatic bit pat(input int seed, input int f, input int s, input int b);
        int h = seed * 1103 + f * 97 + s * 31 + b * 7 + f * s * 13 + seed * s * 5;
        return h[3] ^ h[0] ^ h[5];
    endfunction

    // kind: 0 none, 1 los, 2 lof, 3 slip, 4 resync
    task automatic run_mf(input int seed, input bit esf, input int ev_at, input int kind, input bit gaps);
        int n = 0;
        esf_mode = esf;
        for (int f = 0; f < (esf ? 24 : 12); f++)
            for (int s = 0; s < 24; s++)
                for (int b = 0; b < 8; b++) begin
                    bit on = (kind != 0) && (n >= ev_at) && (n < ev_at + ((kind == 4) ? 1 : 3));
                    if (gaps && (n % 11 == 5))
                        step(!pat(seed, f, s, b), 1'b0, f, s, 7, 1'b0, 1'b0, 1'b0, 1'b0);
                    step(pat(seed, f, s, b), 1'b1, f, s, b,
                         on && kind == 1, on && kind == 2, on && kind == 3, on && kind == 4);
                    n++;
                end
    endtask

    initial begin
        #(4 * 190000);
        fails++;
        $display("FAIL watchdog R1-all timeout actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [95:0] saved;
        bit ok;
        for (int c = 0; c < 24; c++) m_sh[c] = '0;
        repeat (3) @(posedge clk);
        #1;
        chk(sig_bank === '0, "R1 reset bank", sig_bank, '0);
        chk(freeze_o === 1'b0, "R1 reset freeze", 96'(freeze_o), 0);
        chk(resync_irq === 1'b0, "R1 reset irq", 96'(resync_irq), 0);
        rst = 1'b0;

        run_mf(1, 1'b1, 0, 0, 1'b0);
        run_mf(2, 1'b1, 0, 0, 1'b1);               // R12 gaps with inverted data
        saved = sig_bank;
        run_mf(3, 1'b1, 100, 1, 1'b0);             // R7 los mid multiframe
        chk(freeze_o === 1'b1, "R7 frozen after los", 96'(freeze_o), 1);
        chk(sig_bank === saved, "R7 bank held", sig_bank, saved);
        run_mf(4, 1'b1, 0, 0, 1'b0);               // R10 clean multiframe releases
        chk(freeze_o === 1'b0, "R10 released", 96'(freeze_o), 0);
        run_mf(5, 1'b1, 0, 3, 1'b0);               // slip at first bit
        run_mf(6, 1'b1, 3000, 2, 1'b0);            // lof while armed
        chk(freeze_o === 1'b1, "R10 armed multiframe upset", 96'(freeze_o), 1);
        run_mf(7, 1'b1, 0, 0, 1'b0);
        chk(freeze_o === 1'b0, "R10 released again", 96'(freeze_o), 0);
        auto_frz_off = 1'b1;
        run_mf(8, 1'b1, 50, 2, 1'b0);              // R8
        chk(freeze_o === 1'b0, "R8 no auto freeze", 96'(freeze_o), 0);
        run_mf(9, 1'b1, 10, 4, 1'b0);              // R9
        chk(freeze_o === 1'b1, "R9 resync freezes", 96'(freeze_o), 1);
        run_mf(10, 1'b1, 0, 0, 1'b0);
        chk(freeze_o === 1'b0, "R9 R10 release after resync", 96'(freeze_o), 0);
        auto_frz_off = 1'b0;
        run_mf(11, 1'b0, 0, 0, 1'b0);              // R4
        run_mf(12, 1'b0, 0, 0, 1'b1);
        ok = 1'b1;
        for (int c = 0; c < 24; c++) begin
            logic [3:0] nb = sig_bank[8 * (c / 2) + ((c % 2 == 0) ? 4 : 0) +: 4];
            if (nb[3] !== nb[1] || nb[2] !== nb[0]) ok = 1'b0;
        end
        chk(ok, "R4 lane duplication", sig_bank, m_bank);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule